// File: doc/BRIEF.md
# A/D Conversion Sequencer Controller

This block is the digital control around an analog-to-digital converter. It walks the converter through an ascending range of input channels, from a first to a last channel number. For each channel it hands one conversion to the converter through a start/done handshake, files the result in that channel's result register and pulses that channel's completion flag. A sequence can be launched by software, by an external pin pulse or by a timer underflow pulse. It runs either once or over and over.

The control inputs are level settings that a register file elsewhere holds: the run bit, the repeat-mode bit, the trigger selector, the voltage-range field, the channel bounds and the module enable. The run bit never clears itself. For the software trigger, its rising edge starts a sequence. For the pin and timer triggers, it only allows triggers to be accepted. Dropping it asks for a stop, and the conversion already handed to the converter always finishes first.

The controller is a three-state machine. IDLE goes to ISSUE when an accepted start event arrives and the voltage range is non-zero. ISSUE goes to WAIT when the start pulse is issued, or back to IDLE when a stop is requested before issue. WAIT goes to ISSUE for the next channel, or back to ISSUE at the first channel in repeat mode. WAIT goes to IDLE at the end of a one-time sequence, or when a stop is pending as the conversion completes. Clearing the module enable forces IDLE from any state.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, busy, conv_start, done_flag and every result register are 0, and ch_stat reads 0.
- R2: With trig_sel = 0 (software), a 0-to-1 change of run starts a sequence. conv_start pulses once per channel, with conv_ch stepping up from ch_first to ch_last.
- R3: run is never cleared by the block. After a one-time sequence ends with run still 1, no further conversion starts until run goes to 0 and back to 1.
- R4: When run drops while a conversion is with the converter, that conversion completes and its result is stored. The block then goes idle and issues no further conv_start.
- R5: With cont_mode = 1, the sequence restarts at ch_first after ch_last and repeats until stopped. With cont_mode = 0, it ends after ch_last.
- R6: With trig_sel = 1 (pin) or 2 (timer), run only enables acceptance. A sequence starts on a pulse of the selected source only (pin_trig or tmr_ufl). Pulses of the other source, and pulses while not enabled, are ignored.
- R7: While vrange = 0, no sequence starts and conv_start is never raised. Any non-zero value, including 3, permits conversion.
- R8: For the timer trigger, run = 1 takes effect only once sampled at one tmr_tick strobe. It is withdrawn only after it reads 0 at ZERO_TICKS (default 2) consecutive strobes. One zero strobe does not disable it.
- R9: busy is 1 from the cycle after a start event until the sequence ends. While mod_en = 0 the block is held idle with busy = 0, and it does not resume when mod_en returns to 1.
- R10: While busy, ch_stat equals the channel being converted. When idle, it shows the last converted channel, except that it reads 0 when that channel was the top channel NCH-1.
- R11: A completed conversion stores conv_data into the result field of its channel (res_flat bits ch*DW and up). The matching done_flag bit is high for exactly one cycle, in the cycle the result appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mod_en | input | 1 | Module enable; 0 holds the block idle |
| run | input | 1 | Run/enable bit (level, never self-clearing) |
| cont_mode | input | 1 | 0 one-time sequence, 1 repeating |
| trig_sel | input | 2 | 0 software, 1 pin, 2 timer, 3 as software |
| vrange | input | 2 | Voltage range; 0 forbids conversion |
| ch_first | input | 3 | First channel of the sequence |
| ch_last | input | 3 | Last channel of the sequence |
| pin_trig | input | 1 | External trigger pulse |
| tmr_tick | input | 1 | One-cycle strobe per timer clock period |
| tmr_ufl | input | 1 | Timer underflow trigger pulse |
| conv_done | input | 1 | Converter finished the issued conversion |
| conv_data | input | 12 | Converter result, valid with conv_done |
| conv_start | output | 1 | One-cycle request to start a conversion |
| conv_ch | output | 3 | Channel for the requested conversion |
| busy | output | 1 | Sequence in progress |
| ch_stat | output | 3 | Channel status field |
| res_flat | output | 96 | Per-channel result registers, channel 0 in the low bits |
| done_flag | output | 8 | Per-channel completion pulse |

## Verification
The bench drops run just after a conversion has been handed over. A design that abandons in-flight work would lose that result, and one that ignores the stop would keep issuing channels. It holds run at 1 after a one-time sequence, to catch a controller that restarts on level instead of edge. It offers the timer path a single zero strobe, which must not disable it, and then two zero strobes, which must. It checks ch_stat after sequences ending on channel 7 and on lower channels, so a missing wrap to 0 or an off-by-one status shows up. It also checks that a zero voltage range, a wrong trigger source and a cleared module enable each leave the converter untouched.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_WAIT  = 2'd2
    } sq_state_t;

    localparam logic [1:0] TRG_SOFT = 2'd0;
    localparam logic [1:0] TRG_PIN  = 2'd1;
    localparam logic [1:0] TRG_TMR  = 2'd2;

endpackage

// File: rtl/adc_trig_gate.sv
module adc_trig_gate
    import adc_seq_pkg::*;
#(
    parameter int ZERO_TICKS = 2,
    localparam int ZC_W = $clog2(ZERO_TICKS + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mod_en,
    input  logic       run,
    input  logic [1:0] trig_sel,
    input  logic       pin_trig,
    input  logic       tmr_tick,
    input  logic       tmr_ufl,
    output logic       start_evt,
    output logic       run_eff
);

    logic            run_q;
    logic            tm_en;
    logic [ZC_W-1:0] zcnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            tm_en <= 1'b0;
            zcnt  <= '0;
        end else if (!mod_en) begin
            run_q <= run;
            tm_en <= 1'b0;
            zcnt  <= '0;
        end else begin
            run_q <= run;
            if (tmr_tick) begin
                if (run) begin
                    tm_en <= 1'b1;
                    zcnt  <= '0;
                end else if (zcnt >= ZC_W'(ZERO_TICKS - 1)) begin
                    tm_en <= 1'b0;
                end else begin
                    zcnt <= zcnt + 1'b1;
                end
            end
        end
    end

    always_comb begin
        unique case (trig_sel)
            TRG_PIN: begin
                start_evt = pin_trig & run;
                run_eff   = run;
            end
            TRG_TMR: begin
                start_evt = tmr_ufl & tm_en;
                run_eff   = tm_en;
            end
            default: begin
                start_evt = run & ~run_q;
                run_eff   = run;
            end
        endcase
    end

    // R8: timer enable rises only on a strobe
    p_tmr_arm_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tm_en) |-> $past(tmr_tick));

    // R8: timer enable falls only after a zero strobe or module disable
    p_tmr_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tm_en) |-> ($past(!run && tmr_tick) || $past(!mod_en)));

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int NCH = 8,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mod_en,
    input  logic            start_evt,
    input  logic            run_eff,
    input  logic            vrange_ok,
    input  logic            cont,
    input  logic [CH_W-1:0] ch_first,
    input  logic [CH_W-1:0] ch_last,
    input  logic            conv_done,
    output logic            conv_start,
    output logic [CH_W-1:0] conv_ch,
    output logic            busy,
    output logic [CH_W-1:0] ch_stat,
    output logic            cap_en,
    output logic [CH_W-1:0] cap_ch
);

    localparam logic [CH_W-1:0] TOP_CH = CH_W'(NCH - 1);

    sq_state_t       state, nxt;
    logic [CH_W-1:0] cur_ch, nxt_ch;
    logic [CH_W-1:0] last_ch;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SQ_IDLE;
            cur_ch  <= '0;
            last_ch <= '0;
        end else if (!mod_en) begin
            state   <= SQ_IDLE;
        end else begin
            state  <= nxt;
            cur_ch <= nxt_ch;
            if (cap_en) last_ch <= cur_ch;
        end
    end

    // next state
    always_comb begin
        nxt    = state;
        nxt_ch = cur_ch;
        unique case (state)
            SQ_IDLE: begin
                if (start_evt && vrange_ok) begin
                    nxt    = SQ_ISSUE;
                    nxt_ch = ch_first;
                end
            end
            SQ_ISSUE: begin
                if (conv_start)    nxt = SQ_WAIT;
                else if (!run_eff) nxt = SQ_IDLE;
            end
            SQ_WAIT: begin
                if (conv_done) begin
                    if (!run_eff) begin
                        nxt = SQ_IDLE;
                    end else if (cur_ch == ch_last) begin
                        if (cont) begin
                            nxt    = SQ_ISSUE;
                            nxt_ch = ch_first;
                        end else begin
                            nxt = SQ_IDLE;
                        end
                    end else begin
                        nxt    = SQ_ISSUE;
                        nxt_ch = cur_ch + 1'b1;
                    end
                end
            end
            default: nxt = SQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy       = (state != SQ_IDLE);
        conv_start = (state == SQ_ISSUE) & vrange_ok & run_eff & mod_en;
        conv_ch    = cur_ch;
        cap_en     = (state == SQ_WAIT) & conv_done & mod_en;
        cap_ch     = cur_ch;
        if (busy)                  ch_stat = cur_ch;
        else if (last_ch == TOP_CH) ch_stat = '0;
        else                       ch_stat = last_ch;
    end

    // R2: a start request lasts one cycle
    p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R4: an issued conversion keeps the block busy until it completes
    p_issue_holds_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && mod_en) |=> busy);

    // R9: module disable forces idle
    p_gate_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_en |=> !busy);

    // R10: the status tracks the issued channel while busy
    p_stat_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> (ch_stat == conv_ch));

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
    parameter int NCH = 8,
    parameter int DW  = 12,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [CH_W-1:0]   cap_ch,
    input  logic [DW-1:0]     cap_data,
    output logic [NCH*DW-1:0] res_flat,
    output logic [NCH-1:0]    done_flag
);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [DW-1:0] res_q;
        logic          hit;

        assign hit = cap_en && (cap_ch == CH_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                res_q        <= '0;
                done_flag[g] <= 1'b0;
            end else begin
                done_flag[g] <= hit;
                if (hit) res_q <= cap_data;
            end
        end

        assign res_flat[g*DW +: DW] = res_q;
    end

    // R11: at most one channel completes per cycle
    p_done_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done_flag));

    // R11: a completion flag follows a capture
    p_done_after_cap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done_flag != '0) |-> $past(cap_en));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int NCH        = 8,
    parameter int DW         = 12,
    parameter int ZERO_TICKS = 2,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mod_en,
    input  logic              run,
    input  logic              cont_mode,
    input  logic [1:0]        trig_sel,
    input  logic [1:0]        vrange,
    input  logic [CH_W-1:0]   ch_first,
    input  logic [CH_W-1:0]   ch_last,
    input  logic              pin_trig,
    input  logic              tmr_tick,
    input  logic              tmr_ufl,
    input  logic              conv_done,
    input  logic [DW-1:0]     conv_data,
    output logic              conv_start,
    output logic [CH_W-1:0]   conv_ch,
    output logic              busy,
    output logic [CH_W-1:0]   ch_stat,
    output logic [NCH*DW-1:0] res_flat,
    output logic [NCH-1:0]    done_flag
);

    logic            start_evt;
    logic            run_eff;
    logic            vrange_ok;
    logic            cap_en;
    logic [CH_W-1:0] cap_ch;

    assign vrange_ok = (vrange != 2'd0);

    adc_trig_gate #(.ZERO_TICKS(ZERO_TICKS)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .mod_en   (mod_en),
        .run      (run),
        .trig_sel (trig_sel),
        .pin_trig (pin_trig),
        .tmr_tick (tmr_tick),
        .tmr_ufl  (tmr_ufl),
        .start_evt(start_evt),
        .run_eff  (run_eff)
    );

    adc_seq_fsm #(.NCH(NCH)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mod_en    (mod_en),
        .start_evt (start_evt),
        .run_eff   (run_eff),
        .vrange_ok (vrange_ok),
        .cont      (cont_mode),
        .ch_first  (ch_first),
        .ch_last   (ch_last),
        .conv_done (conv_done),
        .conv_start(conv_start),
        .conv_ch   (conv_ch),
        .busy      (busy),
        .ch_stat   (ch_stat),
        .cap_en    (cap_en),
        .cap_ch    (cap_ch)
    );

    adc_result_bank #(.NCH(NCH), .DW(DW)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .cap_ch   (cap_ch),
        .cap_data (conv_data),
        .res_flat (res_flat),
        .done_flag(done_flag)
    );

    // R7: a sequence only begins under a permitted voltage range
    p_busy_needs_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(vrange != 2'd0));

endmodule

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;

    localparam int NCH = 8;
    localparam int DW  = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mod_en = 1'b1;
    logic              run = 1'b0;
    logic              cont_mode = 1'b0;
    logic [1:0]        trig_sel = 2'd0;
    logic [1:0]        vrange = 2'd3;
    logic [2:0]        ch_first = 3'd0;
    logic [2:0]        ch_last = 3'd0;
    logic              pin_trig = 1'b0;
    logic              tmr_tick = 1'b0;
    logic              tmr_ufl = 1'b0;
    logic              conv_done = 1'b0;
    logic [DW-1:0]     conv_data = '0;
    logic              conv_start;
    logic [2:0]        conv_ch;
    logic              busy;
    logic [2:0]        ch_stat;
    logic [NCH*DW-1:0] res_flat;
    logic [NCH-1:0]    done_flag;

    adc_seq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .run(run),
        .cont_mode(cont_mode), .trig_sel(trig_sel), .vrange(vrange),
        .ch_first(ch_first), .ch_last(ch_last), .pin_trig(pin_trig),
        .tmr_tick(tmr_tick), .tmr_ufl(tmr_ufl), .conv_done(conv_done),
        .conv_data(conv_data), .conv_start(conv_start), .conv_ch(conv_ch),
        .busy(busy), .ch_stat(ch_stat), .res_flat(res_flat),
        .done_flag(done_flag)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // converter model and monitor
    int       log_n = 0;
    int       log_ch [0:63];
    int       done_cnt [0:NCH-1];
    int       pend = 0;
    logic [2:0] pch = '0;

    initial for (int i = 0; i < NCH; i++) done_cnt[i] = 0;

    always @(negedge clk) begin
        conv_done = 1'b0;
        if (pend == 1) begin
            conv_done = 1'b1;
            conv_data = 12'hA00 | DW'(pch);
        end
        if (pend > 0) pend--;
        if (rst_n && conv_start) begin
            pend = 3;
            pch  = conv_ch;
            if (log_n < 64) log_ch[log_n] = int'(conv_ch);
            log_n++;
            chk(ch_stat == conv_ch, "R10 status during conversion", int'(ch_stat), int'(conv_ch));
        end
        if (rst_n && done_flag != '0) begin
            for (int c = 0; c < NCH; c++) begin
                if (done_flag[c]) begin
                    done_cnt[c]++;
                    chk(res_flat[c*DW +: DW] == (12'hA00 | DW'(c)), "R11 result on done",
                        int'(res_flat[c*DW +: DW]), int'(12'hA00 | DW'(c)));
                end
            end
        end
    end

    task automatic tick(input int n = 1);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic clear_log();
        log_n = 0;
        for (int i = 0; i < NCH; i++) done_cnt[i] = 0;
    endtask

    task automatic wait_idle();
        int g = 0;
        while (busy && g < 400) begin
            tick();
            g++;
        end
    endtask

    task automatic wait_log(input int n);
        int g = 0;
        while (log_n < n && g < 400) begin
            tick();
            g++;
        end
    endtask

    task automatic pulse_tick();
        tmr_tick = 1'b1; tick(); tmr_tick = 1'b0; tick();
    endtask

    task automatic pulse_pin();
        pin_trig = 1'b1; tick(); pin_trig = 1'b0;
    endtask

    task automatic pulse_ufl();
        tmr_ufl = 1'b1; tick(); tmr_ufl = 1'b0;
    endtask

    function automatic int total_done();
        int s = 0;
        for (int i = 0; i < NCH; i++) s += done_cnt[i];
        return s;
    endfunction

    // {trig_sel, ch_first, ch_last, vrange}
    localparam logic [9:0] VEC [0:4] = '{
        {2'd0, 3'd0, 3'd3, 2'd3},
        {2'd1, 3'd2, 3'd5, 2'd3},
        {2'd2, 3'd4, 3'd7, 2'd3},
        {2'd0, 3'd5, 3'd5, 2'd1},
        {2'd1, 3'd6, 3'd7, 2'd2}
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(conv_start == 1'b0, "R1 conv_start", int'(conv_start), 0);
        chk(ch_stat == 3'd0, "R1 ch_stat", int'(ch_stat), 0);
        chk(res_flat == '0, "R1 results", int'(res_flat[DW-1:0]), 0);
        chk(done_flag == '0, "R1 done", int'(done_flag), 0);

        // table walk: one-time sequences under each trigger source (R2, R6, R10, R11)
        for (int v = 0; v < 5; v++) begin
            logic [1:0] sel;
            int f, l, nexp, sexp;
            sel = VEC[v][9:8];
            f = int'(VEC[v][7:5]);
            l = int'(VEC[v][4:2]);
            trig_sel = sel; ch_first = 3'(f); ch_last = 3'(l);
            vrange = VEC[v][1:0]; cont_mode = 1'b0;
            tick(2);
            clear_log();
            run = 1'b1;
            if (sel == 2'd1) begin
                tick(2); pulse_pin();
            end else if (sel == 2'd2) begin
                pulse_tick(); pulse_ufl();
            end
            tick();
            chk(busy == 1'b1, "R9 busy after start", int'(busy), 1);
            wait_idle();
            tick(2);
            nexp = l - f + 1;
            chk(log_n == nexp, "R2 sequence length", log_n, nexp);
            for (int k = 0; k < nexp && k < log_n; k++)
                chk(log_ch[k] == f + k, "R2 ascending order", log_ch[k], f + k);
            chk(total_done() == nexp, "R11 done pulse count", total_done(), nexp);
            sexp = (l == NCH - 1) ? 0 : l;
            chk(int'(ch_stat) == sexp, "R10 status after one-time end", int'(ch_stat), sexp);
            run = 1'b0;
            if (sel == 2'd2) begin pulse_tick(); pulse_tick(); end
            tick(2);
        end

        // R3: level run does not restart; 0 then 1 does
        trig_sel = 2'd0; ch_first = 3'd1; ch_last = 3'd2; vrange = 2'd3; cont_mode = 1'b0;
        run = 1'b1; tick(); wait_idle(); tick(2);
        clear_log();
        tick(20);
        chk(log_n == 0 && busy == 1'b0, "R3 no restart while run held", log_n, 0);
        run = 1'b0; tick(); run = 1'b1; tick();
        wait_idle(); tick(2);
        chk(log_n == 2, "R3 restart after 0 then 1", log_n, 2);
        run = 1'b0; tick(2);

        // R4: stop lets in-flight conversion finish
        ch_first = 3'd0; ch_last = 3'd7; cont_mode = 1'b1;
        clear_log();
        run = 1'b1;
        wait_log(3);
        tick();
        run = 1'b0;
        wait_idle(); tick(6);
        chk(log_n == 3, "R4 no issue after stop", log_n, 3);
        chk(total_done() == 3, "R4 in-flight conversion completed", total_done(), 3);
        chk(ch_stat == 3'd2, "R10 status after forced stop", int'(ch_stat), 2);

        // R5: repeat mode wraps to the first channel
        ch_first = 3'd5; ch_last = 3'd6; cont_mode = 1'b1;
        tick(); clear_log();
        run = 1'b1;
        wait_log(5);
        tick();
        run = 1'b0;
        wait_idle(); tick(6);
        chk(log_n == 5, "R5 repeat count", log_n, 5);
        for (int k = 0; k < 5 && k < log_n; k++)
            chk(log_ch[k] == 5 + (k % 2), "R5 repeat order", log_ch[k], 5 + (k % 2));
        cont_mode = 1'b0;

        // R7: zero voltage range blocks every start
        ch_first = 3'd0; ch_last = 3'd1; vrange = 2'd0;
        trig_sel = 2'd1; clear_log();
        run = 1'b1; tick(2); pulse_pin(); tick(10);
        chk(log_n == 0 && busy == 1'b0, "R7 pin trigger blocked", log_n, 0);
        run = 1'b0; trig_sel = 2'd0; tick(2);
        run = 1'b1; tick(10);
        chk(log_n == 0 && busy == 1'b0, "R7 software start blocked", log_n, 0);
        run = 1'b0; vrange = 2'd3; tick(2);

        // R6: only the selected source while enabled
        trig_sel = 2'd1; clear_log();
        pulse_pin(); tick(8);
        chk(log_n == 0, "R6 pin ignored while run low", log_n, 0);
        run = 1'b1; tick();
        pulse_tick(); pulse_ufl(); tick(8);
        chk(log_n == 0, "R6 timer pulse ignored in pin mode", log_n, 0);
        pulse_pin(); tick(); wait_idle(); tick(2);
        chk(log_n == 2, "R6 pin trigger accepted", log_n, 2);
        run = 1'b0; tick(2);

        // R8: timer-side hold rules
        mod_en = 1'b0; tick(); mod_en = 1'b1; tick();
        trig_sel = 2'd2; clear_log();
        run = 1'b1; tick(2); pulse_ufl(); tick(8);
        chk(log_n == 0, "R8 run without strobe not recognised", log_n, 0);
        pulse_tick(); pulse_ufl(); tick(); wait_idle(); tick(2);
        chk(log_n == 2, "R8 run recognised after one strobe", log_n, 2);
        run = 1'b0; pulse_tick(); run = 1'b1; tick();
        clear_log(); pulse_ufl(); tick(); wait_idle(); tick(2);
        chk(log_n == 2, "R8 single zero strobe keeps enable", log_n, 2);
        pulse_tick();
        run = 1'b0; pulse_tick(); pulse_tick();
        clear_log(); pulse_ufl(); tick(8);
        chk(log_n == 0, "R8 two zero strobes disable", log_n, 0);

        // R9: module disable forces idle, no resume
        trig_sel = 2'd0; ch_first = 3'd0; ch_last = 3'd7; cont_mode = 1'b1;
        tick(); clear_log();
        run = 1'b1; tick(3);
        chk(busy == 1'b1, "R9 busy while running", int'(busy), 1);
        mod_en = 1'b0; tick();
        chk(busy == 1'b0, "R9 busy cleared by module disable", int'(busy), 0);
        begin
            int snap;
            snap = log_n;
            tick(10);
            chk(log_n == snap, "R9 no issue while disabled", log_n, snap);
            mod_en = 1'b1; tick(10);
            chk(busy == 1'b0 && log_n == snap, "R9 no resume on enable", log_n, snap);
        end
        run = 1'b0; cont_mode = 1'b0; tick(5);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule